// File: doc/BRIEF.md
# Four-Rail Power Sequencing Controller

This block switches four supply rails on and off in a programmed order. It first waits until enable, the system-reset request line and every rail's undervoltage-OK flag have all been good without a break for a long qualification window. It then starts one turn-on delay per rail, all at the same moment, and enables each rail's gate when that rail's own delay runs out. Once every gate reports that it is at full level, a stability timer runs, and the active-low reset output is released only when that timer ends.

While the rails are up, a filtered undervoltage fault, or a low level on the system-reset request line, turns every gate off at once and drives the strong pulldowns. The block then stays in that fault state until enable is cycled. A normal disable drives reset low first. It then starts one turn-off delay per rail, all together, so the rails drop in their own programmed order. Each rail's strong pulldown is applied once that rail's gate feedback shows it has fallen below the low threshold.

Every time interval is counted in pulses of the `tick` timebase input. The delay for each rail is an unsigned 16-bit value.

Top module: `rail_seq_top`

## Requirements
- R1: After reset, gate_en and gate_pd are 0000, reset_n is 0 and sysrst_n is 1.
- R2: Turn-on starts only after enable, sysrst_req_n and all four uv_ok bits have stayed high for QUAL_TICKS ticks in a row. Any break in that condition restarts the count from zero.
- R3: When qualification ends, all four turn-on counters start together. gate_en[i] rises one clock after the tick on which QUAL_TICKS+on_dly[i] ticks have been counted since the condition first held, so a delay of 0 puts that gate on with the end of qualification. The counters clear on expiry, so the next power-up gives the same timing.
- R4: reset_n rises on the clock after STAB_TICKS ticks have been counted while all gates are enabled and all gate_full bits are high. reset_n is never high unless all four gates are enabled.
- R5: After all gates are enabled (stabilization and run), a uv_ok bit that stays low for fewer than GLITCH_TICKS ticks is ignored. A bit that stays low for GLITCH_TICKS ticks is a fault.
- R6: On a fault, from the next clock gate_en is 0000, gate_pd is 1111, and reset_n and sysrst_n are both 0.
- R7: The fault state holds while enable stays high, even if uv_ok recovers. Driving enable low returns the block to idle (sysrst_n 1, gate_pd 0000), and a new rise of enable restarts qualification.
- R8: enable low while the rails are up drives reset_n low on the next clock with gate_en unchanged. On the clock after that, all four turn-off counters start together, and gate_en[i] falls once its counter has counted off_dly[i] ticks.
- R9: During shutdown, gate_pd[i] is high only when rail i is latched off and gate_low[i] is high. When every rail is off and low, the block returns to idle with gate_pd 0000.
- R10: sysrst_req_n low at any time after qualification turns every gate off on the next clock, with the same outputs and recovery as a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase pulse, one clock wide |
| enable | input | 1 | Sequencer enable |
| sysrst_req_n | input | 1 | Active-low request to drop all rails immediately |
| uv_ok | input | 4 | Per-rail undervoltage-OK flags |
| gate_full | input | 4 | Per-rail gate-at-full-level feedback |
| gate_low | input | 4 | Per-rail gate-below-low-threshold feedback |
| on_dly | input | 4x16 | Per-rail turn-on delay in ticks |
| off_dly | input | 4x16 | Per-rail turn-off delay in ticks |
| gate_en | output | 4 | Per-rail gate enable |
| gate_pd | output | 4 | Per-rail strong pulldown strobe |
| reset_n | output | 1 | Active-low reset, released when the rails are stable |
| sysrst_n | output | 1 | Active-low system reset, low in the fault state |

## Verification
The assertions assume that on_dly and off_dly do not change while a sequence is running, and that tick is a single-clock pulse. The bench sets both delay tables once before reset and drives tick from a free-running divider, one clock in every four. The assertions also assume that gate_low and gate_full follow gate_en with some lag. The bench models each rail with age counters, so each flag settles eight clocks after the gate changes, and it never drives both flags high for the same rail.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RAMP  = 3'd1,
        ST_STAB  = 3'd2,
        ST_RUN   = 3'd3,
        ST_SHRST = 3'd4,
        ST_SHUT  = 3'd5,
        ST_FAULT = 3'd6
    } seq_state_e;

endpackage

// File: rtl/rail_dly_ctr.sv
module rail_dly_ctr #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          run_i,
    input  logic          tick_i,
    input  logic [DW-1:0] limit_i,
    output logic          fired_o
);

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          fired;
    } dly_t;

    dly_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (clr_i) begin
            r_d.cnt   = '0;
            r_d.fired = 1'b0;
        end else if (run_i && !r_q.fired) begin
            if (r_q.cnt == limit_i) begin
                r_d.fired = 1'b1;
                r_d.cnt   = '0;
            end else if (tick_i) begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign fired_o = r_q.fired;

    // R3: a running counter never passes its limit before firing
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !r_q.fired && !clr_i) |-> (r_q.cnt <= limit_i));

endmodule

// File: rtl/rail_uv_filter.sv
module rail_uv_filter #(
    parameter int GLITCH_TICKS = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic tick_i,
    input  logic ok_i,
    output logic flt_o
);

    localparam int GW = $clog2(GLITCH_TICKS + 1);
    localparam logic [GW-1:0] G_LIM = GW'(GLITCH_TICKS);

    typedef struct packed {
        logic [GW-1:0] cnt;
    } flt_t;

    flt_t f_q, f_d;

    always_comb begin
        f_d = f_q;
        if (!arm_i || ok_i) begin
            f_d.cnt = '0;
        end else if (tick_i && (f_q.cnt != G_LIM)) begin
            f_d.cnt = f_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign flt_o = arm_i && !ok_i && (f_q.cnt == G_LIM);

    // R5: a good flag always wipes the low-time count
    p_filter_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ok_i |=> (f_q.cnt == '0));

endmodule

// File: rtl/rail_seq_top.sv
module rail_seq_top
    import rail_seq_pkg::*;
#(
    parameter int NRAIL        = 4,
    parameter int DW           = 16,
    parameter int QUAL_TICKS   = 10000,
    parameter int STAB_TICKS   = 160000,
    parameter int GLITCH_TICKS = 30
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick,
    input  logic                      enable,
    input  logic                      sysrst_req_n,
    input  logic [NRAIL-1:0]          uv_ok,
    input  logic [NRAIL-1:0]          gate_full,
    input  logic [NRAIL-1:0]          gate_low,
    input  logic [NRAIL-1:0][DW-1:0]  on_dly,
    input  logic [NRAIL-1:0][DW-1:0]  off_dly,
    output logic [NRAIL-1:0]          gate_en,
    output logic [NRAIL-1:0]          gate_pd,
    output logic                      reset_n,
    output logic                      sysrst_n
);

    localparam int QW = $clog2(QUAL_TICKS + 1);
    localparam int SW = $clog2(STAB_TICKS + 1);
    localparam logic [QW-1:0] Q_END = QW'(QUAL_TICKS - 1);
    localparam logic [SW-1:0] S_END = SW'(STAB_TICKS - 1);

    typedef struct packed {
        seq_state_e    st;
        logic [QW-1:0] qcnt;
        logic [SW-1:0] scnt;
    } ctl_t;

    ctl_t c_q, c_d;

    logic [NRAIL-1:0] on_fired;
    logic [NRAIL-1:0] off_fired;
    logic [NRAIL-1:0] uv_flt;
    logic             on_clr, on_run, off_clr, off_run, flt_arm;
    logic             start_ok, powered, killable;

    assign on_clr  = (c_q.st == ST_IDLE) || (c_q.st == ST_FAULT);
    assign on_run  = (c_q.st == ST_RAMP);
    assign off_clr = (c_q.st != ST_SHUT);
    assign off_run = (c_q.st == ST_SHUT);
    assign flt_arm = (c_q.st == ST_STAB) || (c_q.st == ST_RUN);

    assign start_ok = enable && sysrst_req_n && (&uv_ok);
    assign powered  = (c_q.st == ST_RAMP) || (c_q.st == ST_STAB) || (c_q.st == ST_RUN);
    assign killable = powered || (c_q.st == ST_SHRST) || (c_q.st == ST_SHUT);

    generate
        for (genvar i = 0; i < NRAIL; i++) begin : g_rail
            rail_dly_ctr #(.DW(DW)) u_on (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr_i   (on_clr),
                .run_i   (on_run),
                .tick_i  (tick),
                .limit_i (on_dly[i]),
                .fired_o (on_fired[i])
            );
            rail_dly_ctr #(.DW(DW)) u_off (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr_i   (off_clr),
                .run_i   (off_run),
                .tick_i  (tick),
                .limit_i (off_dly[i]),
                .fired_o (off_fired[i])
            );
            rail_uv_filter #(.GLITCH_TICKS(GLITCH_TICKS)) u_flt (
                .clk    (clk),
                .rst_n  (rst_n),
                .arm_i  (flt_arm),
                .tick_i (tick),
                .ok_i   (uv_ok[i]),
                .flt_o  (uv_flt[i])
            );
        end
    endgenerate

    always_comb begin
        c_d = c_q;
        unique case (c_q.st)
            ST_IDLE: begin
                if (!start_ok) begin
                    c_d.qcnt = '0;
                end else if (tick) begin
                    if (c_q.qcnt == Q_END) begin
                        c_d.st   = ST_RAMP;
                        c_d.qcnt = '0;
                    end else begin
                        c_d.qcnt = c_q.qcnt + 1'b1;
                    end
                end
            end
            ST_RAMP: begin
                if (&on_fired) begin
                    c_d.st   = ST_STAB;
                    c_d.scnt = '0;
                end
            end
            ST_STAB: begin
                if (!(&gate_full)) begin
                    c_d.scnt = '0;
                end else if (tick) begin
                    if (c_q.scnt == S_END) begin
                        c_d.st   = ST_RUN;
                        c_d.scnt = '0;
                    end else begin
                        c_d.scnt = c_q.scnt + 1'b1;
                    end
                end
            end
            ST_RUN: begin
                c_d.st = ST_RUN;
            end
            ST_SHRST: begin
                c_d.st = ST_SHUT;
            end
            ST_SHUT: begin
                if ((&off_fired) && (&gate_low)) begin
                    c_d.st = ST_IDLE;
                end
            end
            ST_FAULT: begin
                if (!enable) begin
                    c_d.st = ST_IDLE;
                end
            end
            default: begin
                c_d.st = ST_FAULT;
            end
        endcase

        if (powered && !enable) begin
            c_d.st   = ST_SHRST;
            c_d.scnt = '0;
        end
        if (killable && !sysrst_req_n) begin
            c_d.st   = ST_FAULT;
            c_d.scnt = '0;
        end
        if (flt_arm && (|uv_flt)) begin
            c_d.st   = ST_FAULT;
            c_d.scnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, qcnt: '0, scnt: '0};
        end else begin
            c_q <= c_d;
        end
    end

    always_comb begin
        gate_en = '0;
        gate_pd = '0;
        if (killable) begin
            gate_en = on_fired & ~off_fired;
        end
        if (c_q.st == ST_FAULT) begin
            gate_pd = '1;
        end else if (c_q.st == ST_SHUT) begin
            gate_pd = off_fired & gate_low;
        end
    end

    assign reset_n  = (c_q.st == ST_RUN);
    assign sysrst_n = (c_q.st != ST_FAULT);

    // R6, R10: a low system reset means every gate is off and pulled down
    p_gate_off_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sysrst_n |-> ((gate_en == '0) && (gate_pd == '1)));

    // R4: reset is released only with every gate enabled
    p_reset_all_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reset_n |-> (&gate_en));

    // R8: reset falls before any gate moves in a normal shutdown
    p_reset_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(reset_n) && sysrst_n) |-> (gate_en == $past(gate_en)));

    // R9: a pulldown never fights an enabled gate
    p_pd_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((gate_pd & gate_en) == '0));

endmodule

// File: tb/tb_rail_seq_top.sv
module tb_rail_seq_top;

    localparam int NR = 4;
    localparam int DW = 16;
    localparam int QT = 20;
    localparam int ST = 30;
    localparam int GT = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic enable = 1'b0;
    logic sysrst_req_n = 1'b1;
    logic [NR-1:0] uv_ok = '0;
    logic [NR-1:0] gate_full;
    logic [NR-1:0] gate_low;
    logic [NR-1:0][DW-1:0] on_dly;
    logic [NR-1:0][DW-1:0] off_dly;
    logic [NR-1:0] gate_en, gate_pd;
    logic reset_n, sysrst_n;

    int nvec = 0;
    int nerr = 0;
    int tcnt = 0;
    bit finished = 1'b0;
    int on_age [NR];
    int off_age[NR];
    logic [1:0] phase = 2'd0;

    int don [NR] = '{3, 12, 7, 0};
    int doff[NR] = '{9, 2, 5, 14};

    rail_seq_top #(
        .NRAIL(NR), .DW(DW), .QUAL_TICKS(QT), .STAB_TICKS(ST), .GLITCH_TICKS(GT)
    ) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable),
        .sysrst_req_n(sysrst_req_n), .uv_ok(uv_ok), .gate_full(gate_full),
        .gate_low(gate_low), .on_dly(on_dly), .off_dly(off_dly),
        .gate_en(gate_en), .gate_pd(gate_pd), .reset_n(reset_n), .sysrst_n(sysrst_n)
    );

    always #4 clk = ~clk;

    always @(negedge clk) begin
        phase <= phase + 2'd1;
        tick  <= (phase == 2'd3);
    end

    always @(posedge clk) begin
        if (tick) tcnt <= tcnt + 1;
        for (int i = 0; i < NR; i++) begin
            if (gate_en[i]) begin
                off_age[i] <= 0;
                if (on_age[i] < 15) on_age[i] <= on_age[i] + 1;
            end else begin
                on_age[i] <= 0;
                if (off_age[i] < 15) off_age[i] <= off_age[i] + 1;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NR; i++) begin
            gate_full[i] = (on_age[i] >= 8);
            gate_low[i]  = (off_age[i] >= 8);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(gate_en == 4'h0, "R1 gate_en", int'(gate_en), 0);
        chk(gate_pd == 4'h0, "R1 gate_pd", int'(gate_pd), 0);
        chk(reset_n == 1'b0, "R1 reset_n", int'(reset_n), 0);
        chk(sysrst_n == 1'b1, "R1 sysrst_n", int'(sysrst_n), 1);
    endtask

    // full power-up; brk drops one uv flag late in qualification (R2)
    task automatic t_powerup(input bit brk, input string tag);
        int base;
        int rise[NR];
        int t_full;
        int t_rst;
        bit seen[NR];
        @(negedge clk);
        enable = 1'b1;
        uv_ok  = '1;
        base   = tcnt;
        if (brk) begin
            while (tcnt - base < QT - 3) @(negedge clk);
            uv_ok[2] = 1'b0;
            @(negedge clk);
            chk(gate_en == 4'h0, "R2 no start on break", int'(gate_en), 0);
            uv_ok[2] = 1'b1;
            base = tcnt;
        end
        foreach (seen[i]) begin seen[i] = 0; rise[i] = -1; end
        t_full = -1;
        t_rst  = -1;
        for (int c = 0; c < 3000 && t_rst < 0; c++) begin
            @(negedge clk);
            for (int i = 0; i < NR; i++) begin
                if (gate_en[i] && !seen[i]) begin
                    seen[i] = 1;
                    rise[i] = tcnt - base;
                end
            end
            if (t_full < 0 && (&gate_full)) begin
                t_full = tcnt;
                chk(reset_n == 1'b0, {"R4 reset low at full ", tag}, int'(reset_n), 0);
            end
            if (reset_n) t_rst = tcnt;
        end
        for (int i = 0; i < NR; i++) begin
            chk(rise[i] == QT + don[i], {"R3 on time ", tag}, rise[i], QT + don[i]);
        end
        chk(t_full >= 0 && t_rst - t_full == ST, {"R4 stability ticks ", tag},
            t_rst - t_full, ST);
        chk(gate_en == 4'hf, {"R4 all gates on ", tag}, int'(gate_en), 15);
    endtask

    task automatic t_glitch_short();
        @(negedge clk);
        uv_ok[1] = 1'b0;
        cyc(4 * (GT - 2));
        uv_ok[1] = 1'b1;
        cyc(20);
        chk(reset_n == 1'b1, "R5 short dip ignored reset", int'(reset_n), 1);
        chk(gate_en == 4'hf, "R5 short dip ignored gates", int'(gate_en), 15);
    endtask

    task automatic t_glitch_long();
        @(negedge clk);
        uv_ok[0] = 1'b0;
        cyc(4 * (GT + 2));
        chk(gate_en == 4'h0, "R5 R6 long dip gates", int'(gate_en), 0);
        chk(gate_pd == 4'hf, "R6 pulldown", int'(gate_pd), 15);
        chk(reset_n == 1'b0, "R6 reset_n", int'(reset_n), 0);
        chk(sysrst_n == 1'b0, "R6 sysrst_n", int'(sysrst_n), 0);
        uv_ok[0] = 1'b1;
    endtask

    task automatic t_fault_hold();
        cyc(200);
        chk(gate_en == 4'h0, "R7 fault held gates", int'(gate_en), 0);
        chk(sysrst_n == 1'b0, "R7 fault held sysrst", int'(sysrst_n), 0);
        enable = 1'b0;
        cyc(2);
        chk(sysrst_n == 1'b1, "R7 idle sysrst", int'(sysrst_n), 1);
        chk(gate_pd == 4'h0, "R7 idle pulldown", int'(gate_pd), 0);
    endtask

    task automatic t_shutdown();
        int toff[NR];
        int c1;
        bit seen[NR];
        foreach (seen[i]) begin seen[i] = 0; toff[i] = -1; end
        c1 = -1;
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk(reset_n == 1'b0, "R8 reset first", int'(reset_n), 0);
        chk(gate_en == 4'hf, "R8 gates held", int'(gate_en), 15);
        for (int c = 0; c < 600; c++) begin
            @(negedge clk);
            for (int i = 0; i < NR; i++) begin
                if (!gate_en[i] && !seen[i]) begin
                    seen[i] = 1;
                    toff[i] = tcnt;
                    if (i == 1) begin
                        c1 = c;
                        chk(gate_pd[1] == 1'b0, "R9 no pd before low", int'(gate_pd[1]), 0);
                    end
                end
            end
            if (c1 >= 0 && c == c1 + 10) begin
                chk(gate_pd[1] == 1'b1, "R9 pd after low", int'(gate_pd[1]), 1);
            end
        end
        for (int i = 1; i < NR; i++) begin
            chk(toff[i] - toff[0] == doff[i] - doff[0], "R8 off order",
                toff[i] - toff[0], doff[i] - doff[0]);
        end
        chk(gate_pd == 4'h0, "R9 idle after shutdown", int'(gate_pd), 0);
        chk(reset_n == 1'b0, "R8 reset stays low", int'(reset_n), 0);
    endtask

    task automatic t_sysrst();
        @(negedge clk);
        sysrst_req_n = 1'b0;
        @(negedge clk);
        sysrst_req_n = 1'b1;
        chk(gate_en == 4'h0, "R10 gates off", int'(gate_en), 0);
        chk(sysrst_n == 1'b0, "R10 sysrst_n", int'(sysrst_n), 0);
        chk(gate_pd == 4'hf, "R10 pulldown", int'(gate_pd), 15);
        cyc(40);
        chk(gate_en == 4'h0, "R10 held off", int'(gate_en), 0);
        enable = 1'b0;
        cyc(2);
        chk(sysrst_n == 1'b1, "R10 recovered", int'(sysrst_n), 1);
    endtask

    initial begin
        for (int i = 0; i < NR; i++) begin
            on_age[i]  = 0;
            off_age[i] = 15;
            on_dly[i]  = DW'(don[i]);
            off_dly[i] = DW'(doff[i]);
        end
        cyc(3);
        t_reset();
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_powerup(1'b0, "first");
        t_glitch_short();
        t_glitch_long();
        t_fault_hold();
        t_powerup(1'b0, "after fault");
        t_shutdown();
        t_powerup(1'b1, "after break");
        t_sysrst();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            nvec++;
            nerr++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

endmodule